// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit with Flag Generation

This unit takes a byte or word operand and applies one of seven shift or rotate operations to it. There are three shifts (logical left, logical right, arithmetic right), two plain rotates and two rotates that pass through the carry bit. The shift count is either the constant one or an 8-bit count value taken from a register. The unit moves the operand by one bit position per clock cycle, so a count larger than the operand width is handled the same way as any other count. A rotate wraps around, and a shift saturates to its fill value.

When the operation finishes, the unit presents the result and five status flags: carry, overflow, sign, zero and parity. It also presents a five-bit update mask. The mask tells the surrounding flag register which of those flags the operation defines. Flags the operation leaves undefined are not written, and a zero count writes none of them. A caller raises `start` for one cycle while the unit is idle and then waits for the `done` pulse.

Top module: `srUnit`

## Requirements
- R1: Shift operations are selected by `opSel` = 0 (logical left), 1 (logical right) and 2 (arithmetic right). Both logical shifts fill the vacated position with zero. The arithmetic right shift refills the top position with a copy of the sign bit. The last bit shifted out lands in `flagCf`.
- R2: Plain rotates are selected by `opSel` = 3 (left) and 4 (right). The bit leaving one end enters the other end and is also copied to `flagCf`. For example, a left rotate of byte F0h by one gives E1h with carry set.
- R3: Rotates through carry are selected by `opSel` = 5 (left) and 6 (right). The incoming carry acts as an extra bit beyond the operand width. A left step moves the carry into bit 0 and the outgoing MSB into carry. A right step moves the carry into the MSB and the outgoing bit 0 into carry.
- R4: With `countSel` = 0 the count is 1. With `countSel` = 1 the count is `countVal`, used at its full 8-bit value without masking. Counts above the operand width are executed bit by bit.
- R5: A count of zero, or the reserved code `opSel` = 7, returns the lane-masked operand unchanged. In that case `flagMask` is 0 and every flag output is 0.
- R6: `flagMask` bit 4 covers CF, bit 3 OF, bit 2 SF, bit 1 ZF and bit 0 PF. A shift sets the CF, SF, ZF and PF bits. A rotate sets only the CF bit. Either kind also sets the OF bit when the count is 1. Any flag output whose mask bit is 0 reads 0.
- R7: For a count of 1, OF is defined per operation. On the left operations it is the new MSB XOR the new CF. On the logical right shift it is the original MSB. On the arithmetic right shift it is 0. On the two right rotates it is the XOR of the two top bits of the result.
- R8: For shifts, SF is the result MSB and ZF is set when the result is zero. PF is set when the low 8 result bits hold an even number of ones.
- R9: With `wideSel` = 0 the unit works on bits 7..0 and bit 7 is the MSB. The upper operand byte is ignored and the upper result byte reads 0. With `wideSel` = 1 the unit works on all 16 bits.
- R10: `start` is accepted only while `busy` is low. For a count N of 1 or more, `busy` stays high until `done` pulses, which happens after the Nth clock edge following the accepting edge. For a count of zero, `done` pulses right after the accepting edge. A `start` raised while busy is ignored. Results hold until the next `done`.
- R11: After reset, `busy` and `done` are low, and the result, all flags and `flagMask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| opSel | input | 3 | Operation code, see R1 to R3 and R5 |
| wideSel | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| operand | input | 16 | Value to shift or rotate |
| countSel | input | 1 | 0 = count of one, 1 = use countVal |
| countVal | input | 8 | Count from the count register |
| carryIn | input | 1 | Current carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| result | output | 16 | Shifted or rotated value |
| flagCf | output | 1 | Carry flag |
| flagOf | output | 1 | Overflow flag |
| flagSf | output | 1 | Sign flag |
| flagZf | output | 1 | Zero flag |
| flagPf | output | 1 | Parity flag |
| flagMask | output | 5 | Flags to write back: {CF, OF, SF, ZF, PF} |

## Verification
Each of the seven operations is driven in both operand widths. The stimuli include single-bit patterns at the MSB and LSB, which show whether the fill value and the carry direction are right. Alternating and mixed patterns separate a rotate from a rotate through carry. Counts of 1, small register counts, and counts of 16, 17 and 40 are used. A count of 1 is the only case that defines OF. Counts of 16, 17 and 40 show whether a shift saturates while a rotate wraps. A byte-mode vector with junk in the upper operand byte confirms that only the low lane is used. Directed cases cover a zero count, the reserved code, a start raised while busy, and the exact done latency for each count.

// File: rtl/srPkg.sv
package srPkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_RSV = 3'd7
  } srOp_e;

  typedef struct packed {
    logic load;     // capture operand and operation
    logic step;     // advance one bit position
    logic finish;   // register result and flags
    logic zeroCnt;  // pass operand through, no flags
    logic oneCnt;   // effective count equals one
  } srStrobe_t;

  localparam int MASK_CF = 4;
  localparam int MASK_OF = 3;
  localparam int MASK_SF = 2;
  localparam int MASK_ZF = 1;
  localparam int MASK_PF = 0;

endpackage

// File: rtl/srControl.sv
module srControl
  import srPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic             countSel,
  input  logic [CNT_W-1:0] countVal,
  output srStrobe_t        strb,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             running;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] effCnt;
  logic             accept;
  logic             zeroCase;

  always_comb begin
    effCnt   = countSel ? countVal : CNT_ONE;
    accept   = start && !running;
    zeroCase = (effCnt == '0) || (srOp_e'(opSel) == OP_RSV);
    strb.load    = accept;
    strb.zeroCnt = accept && zeroCase;
    strb.oneCnt  = (effCnt == CNT_ONE);
    strb.step    = running;
    strb.finish  = (accept && zeroCase) || (running && remaining == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= strb.finish;
      if (accept && !zeroCase) begin
        running   <= 1'b1;
        remaining <= effCnt;
      end else if (running) begin
        remaining <= remaining - CNT_ONE;
        if (remaining == CNT_ONE) running <= 1'b0;
      end
    end
  end

  assign busy = running;

endmodule

// File: rtl/srDatapath.sv
module srDatapath
  import srPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strb,
  input  logic [2:0]        opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              flagCf,
  output logic              flagOf,
  output logic              flagSf,
  output logic              flagZf,
  output logic              flagPf,
  output logic [4:0]        flagMask
);

  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int PAR_W  = 8;
  localparam logic [IDX_W-1:0] WIDE_MSB   = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] NARROW_MSB = IDX_W'(HALF_W - 1);

  // lane masks built per bit
  logic [DATA_W-1:0] wideLane;
  logic [DATA_W-1:0] narrowLane;
  for (genvar b = 0; b < DATA_W; b++) begin : gLane
    assign wideLane[b]   = 1'b1;
    assign narrowLane[b] = (b < HALF_W);
  end

  srOp_e             opReg;
  logic              wideReg;
  logic              oneReg;
  logic [DATA_W-1:0] acc;
  logic              cfReg;

  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] inMask;
  logic [IDX_W-1:0]  msbIdx;
  logic [IDX_W-1:0]  belowIdx;
  logic [DATA_W-1:0] topBit;
  logic [DATA_W-1:0] nxtAcc;
  logic              nxtCf;
  logic              accMsb;
  logic              isShift;
  logic              ofVal;

  always_comb begin
    laneMask = wideReg ? wideLane : narrowLane;
    inMask   = wideSel ? wideLane : narrowLane;
    msbIdx   = wideReg ? WIDE_MSB : NARROW_MSB;
    belowIdx = msbIdx - IDX_W'(1);
    topBit   = '0;
    topBit[msbIdx] = 1'b1;
    accMsb   = acc[msbIdx];
    nxtAcc   = acc;
    nxtCf    = cfReg;
    unique case (opReg)
      OP_SHL: begin
        nxtCf  = accMsb;
        nxtAcc = (acc << 1) & laneMask;
      end
      OP_SHR: begin
        nxtCf  = acc[0];
        nxtAcc = acc >> 1;
      end
      OP_SAR: begin
        nxtCf  = acc[0];
        nxtAcc = (acc >> 1) | (accMsb ? topBit : '0);
      end
      OP_ROL: begin
        nxtCf  = accMsb;
        nxtAcc = ((acc << 1) | DATA_W'(accMsb)) & laneMask;
      end
      OP_ROR: begin
        nxtCf  = acc[0];
        nxtAcc = (acc >> 1) | (acc[0] ? topBit : '0);
      end
      OP_RCL: begin
        nxtCf  = accMsb;
        nxtAcc = ((acc << 1) | DATA_W'(cfReg)) & laneMask;
      end
      OP_RCR: begin
        nxtCf  = acc[0];
        nxtAcc = (acc >> 1) | (cfReg ? topBit : '0);
      end
      default: begin
        nxtCf  = cfReg;
        nxtAcc = acc;
      end
    endcase

    isShift = (opReg == OP_SHL) || (opReg == OP_SHR) || (opReg == OP_SAR);
    unique case (opReg)
      OP_SHL, OP_ROL, OP_RCL: ofVal = nxtAcc[msbIdx] ^ nxtCf;
      OP_SHR:                 ofVal = accMsb;
      OP_ROR, OP_RCR:         ofVal = nxtAcc[msbIdx] ^ nxtAcc[belowIdx];
      default:                ofVal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= OP_RSV;
      wideReg  <= 1'b0;
      oneReg   <= 1'b0;
      acc      <= '0;
      cfReg    <= 1'b0;
      result   <= '0;
      flagCf   <= 1'b0;
      flagOf   <= 1'b0;
      flagSf   <= 1'b0;
      flagZf   <= 1'b0;
      flagPf   <= 1'b0;
      flagMask <= '0;
    end else begin
      if (strb.load) begin
        opReg   <= srOp_e'(opSel);
        wideReg <= wideSel;
        oneReg  <= strb.oneCnt;
        acc     <= operand & inMask;
        cfReg   <= carryIn;
      end else if (strb.step) begin
        acc   <= nxtAcc;
        cfReg <= nxtCf;
      end

      if (strb.finish) begin
        if (strb.zeroCnt) begin
          result   <= operand & inMask;
          flagCf   <= 1'b0;
          flagOf   <= 1'b0;
          flagSf   <= 1'b0;
          flagZf   <= 1'b0;
          flagPf   <= 1'b0;
          flagMask <= '0;
        end else begin
          result   <= nxtAcc;
          flagCf   <= nxtCf;
          flagOf   <= oneReg & ofVal;
          flagSf   <= isShift & nxtAcc[msbIdx];
          flagZf   <= isShift & (nxtAcc == '0);
          flagPf   <= isShift & ~(^nxtAcc[PAR_W-1:0]);
          flagMask[MASK_CF] <= 1'b1;
          flagMask[MASK_OF] <= oneReg;
          flagMask[MASK_SF] <= isShift;
          flagMask[MASK_ZF] <= isShift;
          flagMask[MASK_PF] <= isShift;
        end
      end
    end
  end

endmodule

// File: rtl/srUnit.sv
module srUnit
  import srPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              countSel,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              carryIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flagCf,
  output logic              flagOf,
  output logic              flagSf,
  output logic              flagZf,
  output logic              flagPf,
  output logic [4:0]        flagMask
);

  srStrobe_t strb;

  srControl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opSel    (opSel),
    .countSel (countSel),
    .countVal (countVal),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  srDatapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opSel    (opSel),
    .wideSel  (wideSel),
    .operand  (operand),
    .carryIn  (carryIn),
    .result   (result),
    .flagCf   (flagCf),
    .flagOf   (flagOf),
    .flagSf   (flagSf),
    .flagZf   (flagZf),
    .flagPf   (flagPf),
    .flagMask (flagMask)
  );

endmodule

// File: rtl/srUnitChk.sv
module srUnitChk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        opSel,
  input logic              wideSel,
  input logic              countSel,
  input logic [CNT_W-1:0]  countVal,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        flagMask
);

  localparam int HALF_W = DATA_W / 2;

  logic [2:0]       lastOp;
  logic             lastWide;
  logic [CNT_W-1:0] lastCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastOp   <= '0;
      lastWide <= 1'b0;
      lastCnt  <= '0;
    end else if (start && !busy) begin
      lastOp   <= opSel;
      lastWide <= wideSel;
      lastCnt  <= countSel ? countVal : CNT_W'(1);
    end
  end

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  assert_rot_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastOp >= 3'd3) |-> (flagMask[2:0] == 3'b000));

  assert_of_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastCnt != CNT_W'(1)) |-> !flagMask[3]);

  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && (lastCnt == '0 || lastOp == 3'd7)) |-> (flagMask == 5'd0));

  assert_byte_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !lastWide) |-> (result[DATA_W-1:HALF_W] == '0));

endmodule

bind srUnit srUnitChk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opSel    (opSel),
  .wideSel  (wideSel),
  .countSel (countSel),
  .countVal (countVal),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .flagMask (flagMask)
);

// File: tb/sim_srUnit.sv
module sim_srUnit;

  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic [15:0] opnd;
    logic        csel;
    logic [7:0]  cval;
    logic        cin;
  } stim_t;

  typedef struct packed {
    logic [15:0] res;
    logic        cf, of, sf, zf, pf;
    logic [4:0]  mask;
  } outv_t;

  localparam int NVEC = 16;
  localparam stim_t VEC [NVEC] = '{
    '{3'd0, 1'b1, 16'h8001, 1'b0, 8'd0,  1'b0},
    '{3'd0, 1'b0, 16'h00C3, 1'b1, 8'd2,  1'b0},
    '{3'd1, 1'b0, 16'h0081, 1'b0, 8'd0,  1'b1},
    '{3'd2, 1'b1, 16'h8421, 1'b1, 8'd4,  1'b0},
    '{3'd2, 1'b0, 16'h007F, 1'b1, 8'd3,  1'b0},
    '{3'd3, 1'b1, 16'h8001, 1'b1, 8'd4,  1'b0},
    '{3'd4, 1'b0, 16'h0001, 1'b0, 8'd0,  1'b0},
    '{3'd4, 1'b1, 16'h1235, 1'b1, 8'd17, 1'b0},
    '{3'd5, 1'b0, 16'h0088, 1'b0, 8'd0,  1'b0},
    '{3'd5, 1'b0, 16'h0055, 1'b1, 8'd9,  1'b1},
    '{3'd6, 1'b1, 16'h0001, 1'b0, 8'd0,  1'b1},
    '{3'd6, 1'b1, 16'hF00F, 1'b1, 8'd3,  1'b0},
    '{3'd0, 1'b1, 16'h00FF, 1'b1, 8'd16, 1'b0},
    '{3'd1, 1'b0, 16'hABCD, 1'b1, 8'd4,  1'b0},
    '{3'd2, 1'b1, 16'h8000, 1'b1, 8'd40, 1'b0},
    '{3'd3, 1'b0, 16'h00F0, 1'b1, 8'd0,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic        wideSel = 1'b0;
  logic [15:0] operand = '0;
  logic        countSel = 1'b0;
  logic [7:0]  countVal = '0;
  logic        carryIn = 1'b0;
  logic        busy, done, flagCf, flagOf, flagSf, flagZf, flagPf;
  logic [15:0] result;
  logic [4:0]  flagMask;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  srUnit u0 (.*);

  // Reference behaviour written from the requirements
  function automatic outv_t refModel(stim_t s);
    outv_t o;
    logic [15:0] lane, v, orig;
    logic c;
    int n, m;
    lane = s.wide ? 16'hFFFF : 16'h00FF;
    m    = s.wide ? 15 : 7;
    v    = s.opnd & lane;
    orig = v;
    c    = s.cin;
    n    = s.csel ? int'(s.cval) : 1;
    o    = '0;
    if (n == 0 || s.op == 3'd7) begin
      o.res = v;
      return o;
    end
    for (int i = 0; i < n; i++) begin
      logic top, bot;
      top = v[m];
      bot = v[0];
      case (s.op)
        3'd0: begin c = top; v = (v << 1) & lane; end
        3'd1: begin c = bot; v = v >> 1; end
        3'd2: begin c = bot; v = v >> 1; v[m] = top; end
        3'd3: begin c = top; v = ((v << 1) | 16'(top)) & lane; end
        3'd4: begin c = bot; v = v >> 1; v[m] = bot; end
        3'd5: begin v = ((v << 1) | 16'(c)) & lane; c = top; end
        default: begin v = v >> 1; v[m] = c; c = bot; end
      endcase
    end
    o.res = v;
    o.cf  = c;
    o.mask[4] = 1'b1;
    if (n == 1) begin
      o.mask[3] = 1'b1;
      case (s.op)
        3'd0, 3'd3, 3'd5: o.of = v[m] ^ c;
        3'd1:             o.of = orig[m];
        3'd2:             o.of = 1'b0;
        default:          o.of = v[m] ^ v[m-1];
      endcase
    end
    if (s.op <= 3'd2) begin
      o.mask[2:0] = 3'b111;
      o.sf = v[m];
      o.zf = (v == 16'h0);
      o.pf = ~(^v[7:0]);
    end
    return o;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic outv_t sampleOut();
    outv_t o;
    o.res = result; o.cf = flagCf; o.of = flagOf; o.sf = flagSf;
    o.zf = flagZf; o.pf = flagPf; o.mask = flagMask;
    return o;
  endfunction

  // drive one operation; returns cycles from accept to done
  task automatic runOp(stim_t s, output int cyc);
    @(negedge clk);
    opSel = s.op; wideSel = s.wide; operand = s.opnd;
    countSel = s.csel; countVal = s.cval; carryIn = s.cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cyc;
    stim_t s;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {busy, done, result, flagCf, flagOf, flagSf, flagZf, flagPf, flagMask},
          32'h0);
    rstN = 1'b1;

    // table walk: R1 R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      int expCyc;
      runOp(VEC[i], cyc);
      expCyc = (VEC[i].csel) ? int'(VEC[i].cval) : 1;
      check($sformatf("R1/R2/R3/R6/R7/R8 vec%0d", i), 32'(sampleOut()), 32'(refModel(VEC[i])));
      check($sformatf("R10 latency vec%0d", i), 32'(cyc), 32'(expCyc));
    end

    // R2 hand value: byte F0 rotated left once -> E1, CF=1, OF=0
    runOp('{3'd3, 1'b0, 16'h00F0, 1'b0, 8'd0, 1'b0}, cyc);
    check("R2 rol F0", {result, flagCf, flagOf, flagMask}, {16'h00E1, 1'b1, 1'b0, 5'b11000});

    // R1 hand value: byte 80 arithmetic right by 3 -> F0, CF=0
    runOp('{3'd2, 1'b0, 16'h0080, 1'b1, 8'd3, 1'b1}, cyc);
    check("R1 sar fill", {result, flagCf, flagSf}, {16'h00F0, 1'b0, 1'b1});

    // R3 hand value: byte 88 through carry (cin 0) left once -> 10, CF=1
    runOp('{3'd5, 1'b0, 16'h0088, 1'b0, 8'd0, 1'b0}, cyc);
    check("R3 rcl 88", {result, flagCf}, {16'h0010, 1'b1});

    // R4 count beyond width saturates a logical shift
    runOp('{3'd1, 1'b1, 16'h8000, 1'b1, 8'd20, 1'b1}, cyc);
    check("R4 shr saturate", {result, flagCf, flagZf}, {16'h0000, 1'b0, 1'b1});

    // R5 reserved code passes operand, no flags
    runOp('{3'd7, 1'b1, 16'h1234, 1'b0, 8'd0, 1'b1}, cyc);
    check("R5 reserved op", {result, flagCf, flagMask, 32'(cyc)}, {16'h1234, 1'b0, 5'd0, 32'd0});

    // R9 byte lane ignores upper operand
    runOp('{3'd0, 1'b0, 16'hFF01, 1'b0, 8'd0, 1'b0}, cyc);
    check("R9 byte lane", result, 16'h0002);

    // R10 start while busy ignored
    @(negedge clk);
    opSel = 3'd0; wideSel = 1'b1; operand = 16'h0001; countSel = 1'b1;
    countVal = 8'd5; carryIn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    opSel = 3'd1; operand = 16'hFFFF; countVal = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check("R10 ignore start while busy", {result, flagCf, 32'(cyc)}, {16'h0020, 1'b0, 32'd3});
    @(negedge clk);
    check("R10 result held", result, 16'h0020);

    s = '{3'd6, 1'b0, 16'h0001, 1'b1, 8'd0, 1'b1};
    runOp(s, cyc);
    check("R5 zero count", {result, flagMask, flagCf}, {16'h0001, 5'd0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule